// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks control-flow divergence for a single SIMT wavefront. It keeps a small stack of entries. Each entry holds a program counter, a reconvergence program counter and a per-lane execution mask. The top entry always drives the current pc, the reconvergence pc and the active lane mask to the fetch and issue logic.

On a divergent branch the caller presents the taken target, the fall-through address, the branch's immediate post-dominator and the per-lane taken vector. The block then works in three steps:
- It rewrites the current top entry so that it becomes the rejoin point: its pc takes the post-dominator address and its mask is kept.
- It pushes the fall-through path.
- It pushes the taken path on top of that, so the taken lanes execute first.

Straight-line flow only overwrites the top pc. When the top pc reaches that entry's own reconvergence pc, the entry is dropped automatically and the lanes of the entry beneath become active again. A pop can also be requested explicitly.

Overflow and underflow raise one-cycle error pulses and leave the stack unchanged.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one base entry: pc equals the START_PC parameter, the reconvergence pc is all ones (the sentinel), the mask is all ones, `depth` is 1, and both error outputs are 0.
- R2: `top_pc`, `top_rpc` and `top_mask` always show the fields of the top entry, and `depth` shows the number of entries held (1 to DEPTH).
- R3: With `pc_wr` high and no pop or branch, `pc_new` replaces the top entry's pc from the next cycle on. `depth`, `top_rpc` and `top_mask` are unchanged.
- R4: A branch is divergent when both `mask & br_taken` and `mask & ~br_taken` are nonzero. With room for two entries, a divergent `br_valid` does three things on the edge:
  - the top entry's pc becomes `br_rpc`, with its reconvergence pc and mask kept;
  - an entry {`br_fall_pc`, `br_rpc`, mask & ~`br_taken`} is pushed;
  - an entry {`br_target_pc`, `br_rpc`, mask & `br_taken`} is pushed on top.
  `depth` rises by 2.
- R5: When `depth` > 1 and the top pc equals the top reconvergence pc, the top entry is popped on the next edge, and the entry beneath (its pc, reconvergence pc and mask) becomes the top.
- R6: `pop_req` with `depth` > 1 removes the top entry on the next edge.
- R7: `pop_req` with `depth` = 1 changes nothing, and `err_underflow` is 1 for exactly the following cycle.
- R8: A `br_valid` with no lane taken sets the top pc to `br_fall_pc`. A `br_valid` with every active lane taken sets it to `br_target_pc`. Neither case pushes an entry.
- R9: A divergent branch when fewer than two free slots remain (`depth` > DEPTH-2) changes nothing, and `err_overflow` is 1 for exactly the following cycle.
- R10: Priority is: pop (explicit or automatic) first, then `br_valid`, then `pc_wr`. Only the winning operation takes effect in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_wr | input | 1 | Overwrite top pc (straight-line flow) |
| pc_new | input | PC_W | New pc for the top entry |
| br_valid | input | 1 | Branch resolved this cycle |
| br_target_pc | input | PC_W | Taken-path address |
| br_fall_pc | input | PC_W | Fall-through address |
| br_rpc | input | PC_W | Immediate post-dominator of the branch |
| br_taken | input | LANES | Per-lane taken vector |
| pop_req | input | 1 | Explicit pop request |
| top_pc | output | PC_W | Current pc |
| top_rpc | output | PC_W | Current reconvergence pc |
| top_mask | output | LANES | Active lane mask |
| depth | output | $clog2(DEPTH+1) | Entries held |
| err_overflow | output | 1 | Divergent branch refused, stack full |
| err_underflow | output | 1 | Pop refused, only base entry left |

## Verification
The bench builds the block with DEPTH=4, LANES=8 and PC_W=16. The shallow stack lets a single nested divergence reach the overflow refusal, and eight lanes keep the masks readable in the expected values. With 16-bit pcs the all-ones sentinel stays clear of every address the bench uses. The sequence walks one if/else region in full: divergence, automatic pop and explicit pop. It then collides a pop with a branch, and an automatic pop with a pc write, to exercise the priority order.

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int LANES = 64,
  parameter int PC_W = 32,
  parameter int DEPTH = 8,
  parameter logic [PC_W-1:0] START_PC = '0,
  localparam int SPW = $clog2(DEPTH),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_wr,
  input  logic [PC_W-1:0]  pc_new,
  input  logic             br_valid,
  input  logic [PC_W-1:0]  br_target_pc,
  input  logic [PC_W-1:0]  br_fall_pc,
  input  logic [PC_W-1:0]  br_rpc,
  input  logic [LANES-1:0] br_taken,
  input  logic             pop_req,
  output logic [PC_W-1:0]  top_pc,
  output logic [PC_W-1:0]  top_rpc,
  output logic [LANES-1:0] top_mask,
  output logic [DW-1:0]    depth,
  output logic             err_overflow,
  output logic             err_underflow
);
  localparam logic [SPW-1:0] SP_LIM = SPW'(DEPTH - 3);

  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [SPW-1:0]   sp;

  logic [LANES-1:0] tk_mask, nt_mask;
  logic             reconv_hit, pop_now, split, full;

  assign top_pc   = pc_q[sp];
  assign top_rpc  = rpc_q[sp];
  assign top_mask = mask_q[sp];
  assign depth    = DW'(sp) + DW'(1);

  assign tk_mask    = top_mask & br_taken;
  assign nt_mask    = top_mask & ~br_taken;
  assign split      = (tk_mask != '0) && (nt_mask != '0);
  assign full       = sp > SP_LIM;
  assign reconv_hit = (sp != '0) && (top_pc == top_rpc);
  assign pop_now    = pop_req || reconv_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        pc_q[i]   <= '0;
        rpc_q[i]  <= '0;
        mask_q[i] <= '0;
      end
      pc_q[0]       <= START_PC;
      rpc_q[0]      <= '1;
      mask_q[0]     <= '1;
      sp            <= '0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
      if (pop_now) begin
        if (sp == '0) err_underflow <= 1'b1;
        else          sp <= sp - SPW'(1);
      end else if (br_valid) begin
        if (tk_mask == '0) begin
          pc_q[sp] <= br_fall_pc;
        end else if (nt_mask == '0) begin
          pc_q[sp] <= br_target_pc;
        end else if (full) begin
          err_overflow <= 1'b1;
        end else begin
          pc_q[sp]                <= br_rpc;
          pc_q[sp + SPW'(1)]      <= br_fall_pc;
          rpc_q[sp + SPW'(1)]     <= br_rpc;
          mask_q[sp + SPW'(1)]    <= nt_mask;
          pc_q[sp + SPW'(2)]      <= br_target_pc;
          rpc_q[sp + SPW'(2)]     <= br_rpc;
          mask_q[sp + SPW'(2)]    <= tk_mask;
          sp                      <= sp + SPW'(2);
        end
      end else if (pc_wr) begin
        pc_q[sp] <= pc_new;
      end
    end
  end

  // R2
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth >= DW'(1) && depth <= DW'(DEPTH));

  // R4
  div_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_now && br_valid && split && !full) |=> depth == $past(depth) + DW'(2));

  // R5
  auto_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reconv_hit |=> depth == $past(depth) - DW'(1));

  // R7
  underflow_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> depth == DW'(1));

  // R9
  no_overflow_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_now && br_valid && split && full) |=> err_overflow && $stable(depth));

  // R10
  pop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && sp != '0) |=> depth == $past(depth) - DW'(1));
endmodule

// File: tb/simt_reconv_stack_tb.sv
module simt_reconv_stack_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 8;
  localparam int PC_W = 16;
  localparam int DEPTH = 4;
  localparam int DW = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  rpc;
    logic [LANES-1:0] mask;
    logic [DW-1:0]    dep;
    logic             ovf;
    logic             udf;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pc_wr = 1'b0, br_valid = 1'b0, pop_req = 1'b0;
  logic [PC_W-1:0] pc_new = '0, br_target_pc = '0, br_fall_pc = '0, br_rpc = '0;
  logic [LANES-1:0] br_taken = '0;
  logic [PC_W-1:0] top_pc, top_rpc;
  logic [LANES-1:0] top_mask;
  logic [DW-1:0] depth;
  logic err_overflow, err_underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(16'h0100)) dut_i (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_new(pc_new), .br_valid(br_valid),
    .br_target_pc(br_target_pc), .br_fall_pc(br_fall_pc), .br_rpc(br_rpc),
    .br_taken(br_taken), .pop_req(pop_req), .top_pc(top_pc), .top_rpc(top_rpc),
    .top_mask(top_mask), .depth(depth), .err_overflow(err_overflow),
    .err_underflow(err_underflow));

  function automatic exp_t observed();
    exp_t o;
    o.pc = top_pc; o.rpc = top_rpc; o.mask = top_mask;
    o.dep = depth; o.ovf = err_overflow; o.udf = err_underflow;
    return o;
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t o = observed();
    checks++;
    if (o !== e) begin
      errors++;
      $display("FAIL %s: actual pc=%h rpc=%h mask=%h depth=%0d ovf=%b udf=%b expected pc=%h rpc=%h mask=%h depth=%0d ovf=%b udf=%b",
               tag, o.pc, o.rpc, o.mask, o.dep, o.ovf, o.udf,
               e.pc, e.rpc, e.mask, e.dep, e.ovf, e.udf);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic op(input logic wr, input logic [PC_W-1:0] npc,
                    input logic bv, input logic [PC_W-1:0] tpc, input logic [PC_W-1:0] fpc,
                    input logic [PC_W-1:0] rpc, input logic [LANES-1:0] tk, input logic pop,
                    input exp_t e, input string tag);
    @(negedge clk);
    pc_wr = wr; pc_new = npc; br_valid = bv; br_target_pc = tpc;
    br_fall_pc = fpc; br_rpc = rpc; br_taken = tk; pop_req = pop;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input exp_t e, input string tag);
    op(1'b0, '0, 1'b0, '0, '0, '0, '0, 1'b0, e, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    compare('{16'h0100, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R1 reset");
    // R3 straight-line pc write
    op(1'b1, 16'h0104, 1'b0, '0, '0, '0, '0, 1'b0,
       '{16'h0104, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R3 pc write");
    // R4 divergent branch pushes two, taken on top
    op(1'b0, '0, 1'b1, 16'h0200, 16'h0108, 16'h0300, 8'h0F, 1'b0,
       '{16'h0200, 16'h0300, 8'h0F, 3'd3, 1'b0, 1'b0}, "R4 divergent push");
    // R3/R2 advance taken path to its rejoin pc
    op(1'b1, 16'h0300, 1'b0, '0, '0, '0, '0, 1'b0,
       '{16'h0300, 16'h0300, 8'h0F, 3'd3, 1'b0, 1'b0}, "R3 reach rpc");
    // R5 automatic pop exposes fall-through entry
    idle('{16'h0108, 16'h0300, 8'hF0, 3'd2, 1'b0, 1'b0}, "R5 auto pop");
    // R6 explicit pop restores rejoin entry with full mask
    op(1'b0, '0, 1'b0, '0, '0, '0, '0, 1'b1,
       '{16'h0300, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R6 explicit pop");
    // R7 underflow
    op(1'b0, '0, 1'b0, '0, '0, '0, '0, 1'b1,
       '{16'h0300, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b1}, "R7 underflow pulse");
    idle('{16'h0300, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R7 underflow clears");
    // R8 uniform branches
    op(1'b0, '0, 1'b1, 16'h0400, 16'h0304, 16'h0500, 8'hFF, 1'b0,
       '{16'h0400, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R8 all taken");
    op(1'b0, '0, 1'b1, 16'h0480, 16'h0408, 16'h0500, 8'h00, 1'b0,
       '{16'h0408, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R8 none taken");
    // R4 second divergence, then R9 overflow
    op(1'b0, '0, 1'b1, 16'h0500, 16'h0504, 16'h0600, 8'h03, 1'b0,
       '{16'h0500, 16'h0600, 8'h03, 3'd3, 1'b0, 1'b0}, "R4 second push");
    op(1'b0, '0, 1'b1, 16'h0700, 16'h0704, 16'h0800, 8'h01, 1'b0,
       '{16'h0500, 16'h0600, 8'h03, 3'd3, 1'b1, 1'b0}, "R9 overflow refused");
    // R10 pop beats branch in same cycle
    op(1'b0, '0, 1'b1, 16'h0900, 16'h0904, 16'h0A00, 8'h04, 1'b1,
       '{16'h0504, 16'h0600, 8'hFC, 3'd2, 1'b0, 1'b0}, "R10 pop over branch");
    op(1'b1, 16'h0600, 1'b0, '0, '0, '0, '0, 1'b0,
       '{16'h0600, 16'h0600, 8'hFC, 3'd2, 1'b0, 1'b0}, "R3 fall path to rpc");
    // R10 automatic pop beats pc write
    op(1'b1, 16'h0700, 1'b0, '0, '0, '0, '0, 1'b0,
       '{16'h0600, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R10 auto pop over pc write");
    idle('{16'h0600, 16'hFFFF, 8'hFF, 3'd1, 1'b0, 1'b0}, "R2 base stable");
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule